// File: doc/BRIEF.md
# Fault Event Queue Producer

This block logs faults into a ring of sixteen event records that software drains. Each fault arrives on a one-cycle strobe with five fields: an event code, a stream ID, a substream ID, the input address that faulted, and the address of the table fetch involved. The block packs these fields into a 256-bit record of eight 32-bit words. In the same cycle it writes the record, as one wide beat, into the ring slot that the producer pointer selects. On the next clock edge the producer pointer advances.

Software reads records from the ring memory and then writes the consumer pointer. Both pointers are five bits wide. The low four bits index a slot and bit 4 is a wrap bit. The queue is empty when the two pointers are equal. It is full when the indices match and the wrap bits differ. A fault that arrives while the ring is full is dropped and sets a sticky overflow flag, so no record is ever overwritten. An interrupt line stays high while records are pending and the interrupt is enabled.

Top module: `fault_evq`

## Requirements
- R1: After reset, prod_ptr and cons_ptr are 0 and irq, overflow and mem_we are low.
- R2: Word n of a record sits at mem_data[32n+31:32n]. Word 0 holds the event code in bits 7:0, zeros in bits 11:8 and the substream ID in bits 31:12. Word 1 holds the stream ID. Words 2 and 3 are zero. Words 4 and 5 hold the low and high halves of the input address. Words 6 and 7 hold the low and high halves of the fetch address.
- R3: A fault that is accepted raises mem_we in the same cycle, with mem_idx equal to prod_ptr[3:0]. At the next edge prod_ptr advances by one, modulo 32.
- R4: While evq_enable is low, faults are ignored: mem_we stays low, prod_ptr does not change and overflow is not set.
- R5: When prod_ptr[3:0] equals cons_ptr[3:0] and the wrap bits (bit 4) differ, the ring is full. A fault that arrives then gives no write and leaves prod_ptr unchanged, and overflow is high from the next cycle.
- R6: overflow stays set while evq_enable is high, even after the ring drains. It clears at the first edge at which evq_enable is low.
- R7: When cons_wr is high, cons_ptr takes the value of cons_wdata at the next edge. A fault in that same cycle is checked for space against the old cons_ptr.
- R8: irq is high exactly when evq_irq_enable is high and prod_ptr differs from cons_ptr.
- R9: The pointers wrap from 31 to 0. A record written while prod_ptr is 31 goes to slot 15, and the next record goes to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evq_enable | input | 1 | Event queue enable |
| evq_irq_enable | input | 1 | Event interrupt enable |
| fault_valid | input | 1 | One-cycle fault strobe |
| fault_code | input | 8 | Event code |
| fault_sid | input | 32 | Stream ID |
| fault_ssid | input | 20 | Substream ID |
| fault_iaddr | input | 64 | Faulting input address |
| fault_faddr | input | 64 | Fetch address |
| cons_wr | input | 1 | Consumer pointer write strobe |
| cons_wdata | input | 5 | New consumer pointer |
| prod_ptr | output | 5 | Producer pointer (bit 4 is the wrap bit) |
| cons_ptr | output | 5 | Consumer pointer (bit 4 is the wrap bit) |
| mem_we | output | 1 | Record write strobe |
| mem_idx | output | 4 | Ring slot being written |
| mem_data | output | 256 | Packed eight-word record |
| irq | output | 1 | Level event interrupt |
| overflow | output | 1 | Sticky dropped-fault flag |

## Verification
The occupancy-bound property relies on software never moving the consumer pointer past the producer. After any consumer write, the distance from cons_ptr forward to prod_ptr must stay between 0 and 16. The bench respects this because every value it writes to cons_wdata is either the current producer value or a pointer that the producer has already passed. Faults are driven as single-cycle strobes and each one is held for exactly one cycle, so every strobe is judged once against the pointer state of that cycle.

// File: rtl/fault_evq.sv
module fault_evq #(
  parameter int IDX_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evq_enable,
  input  logic               evq_irq_enable,
  input  logic               fault_valid,
  input  logic [7:0]         fault_code,
  input  logic [31:0]        fault_sid,
  input  logic [19:0]        fault_ssid,
  input  logic [63:0]        fault_iaddr,
  input  logic [63:0]        fault_faddr,
  input  logic               cons_wr,
  input  logic [IDX_W:0]     cons_wdata,
  output logic [IDX_W:0]     prod_ptr,
  output logic [IDX_W:0]     cons_ptr,
  output logic               mem_we,
  output logic [IDX_W-1:0]   mem_idx,
  output logic [255:0]       mem_data,
  output logic               irq,
  output logic               overflow
);
  localparam int PTR_W = IDX_W + 1;
  localparam logic [PTR_W-1:0] WRAP = PTR_W'(1) << IDX_W;

  logic full, take, drop;

  assign full = (prod_ptr ^ cons_ptr) == WRAP;
  assign take = fault_valid && evq_enable && !full;
  assign drop = fault_valid && evq_enable && full;

  assign mem_we  = take;
  assign mem_idx = prod_ptr[IDX_W-1:0];
  assign mem_data = {fault_faddr[63:32], fault_faddr[31:0],
                     fault_iaddr[63:32], fault_iaddr[31:0],
                     32'h0, 32'h0,
                     fault_sid,
                     fault_ssid, 4'h0, fault_code};

  assign irq = evq_irq_enable && (prod_ptr != cons_ptr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_ptr <= '0;
      cons_ptr <= '0;
      overflow <= 1'b0;
    end else begin
      if (take)
        prod_ptr <= prod_ptr + PTR_W'(1);
      if (cons_wr)
        cons_ptr <= cons_wdata;
      if (!evq_enable)
        overflow <= 1'b0;
      else if (drop)
        overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/fault_evq_chk.sv
module fault_evq_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evq_enable,
  input logic             evq_irq_enable,
  input logic             fault_valid,
  input logic             cons_wr,
  input logic [IDX_W:0]   cons_wdata,
  input logic [IDX_W:0]   prod_ptr,
  input logic [IDX_W:0]   cons_ptr,
  input logic             mem_we,
  input logic [255:0]     mem_data,
  input logic             irq,
  input logic             overflow
);
  localparam int PTR_W = IDX_W + 1;
  localparam logic [PTR_W-1:0] DEPTH = PTR_W'(1) << IDX_W;

  logic ring_full;
  logic [PTR_W-1:0] fill;
  assign ring_full = (prod_ptr[IDX_W-1:0] == cons_ptr[IDX_W-1:0]) &&
                     (prod_ptr[IDX_W] != cons_ptr[IDX_W]);
  assign fill = prod_ptr - cons_ptr;

  AST_PROD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> prod_ptr == $past(prod_ptr) + PTR_W'(1)); // R3
  AST_PROD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we |=> $stable(prod_ptr)); // R4
  AST_OFF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !evq_enable |-> !mem_we); // R4
  AST_FULL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ring_full |-> !mem_we); // R5
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && evq_enable && ring_full) |=> overflow); // R5
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= DEPTH); // R5
  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !evq_enable |=> !overflow); // R6
  AST_CONS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cons_wr |=> cons_ptr == $past(cons_wdata)); // R7
  AST_IRQ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (evq_irq_enable && prod_ptr != cons_ptr)); // R8
  AST_REC_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_data[11:8] == 4'h0 && mem_data[127:64] == 64'h0)); // R2
endmodule

bind fault_evq fault_evq_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evq_enable(evq_enable),
  .evq_irq_enable(evq_irq_enable), .fault_valid(fault_valid),
  .cons_wr(cons_wr), .cons_wdata(cons_wdata), .prod_ptr(prod_ptr),
  .cons_ptr(cons_ptr), .mem_we(mem_we), .mem_data(mem_data),
  .irq(irq), .overflow(overflow)
);

// File: tb/sim_fault_evq.sv
`timescale 1ns/1ps
module sim_fault_evq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evq_enable = 1'b0, evq_irq_enable = 1'b0, fault_valid = 1'b0;
  logic [7:0] fault_code = '0;
  logic [31:0] fault_sid = '0;
  logic [19:0] fault_ssid = '0;
  logic [63:0] fault_iaddr = '0, fault_faddr = '0;
  logic cons_wr = 1'b0;
  logic [4:0] cons_wdata = '0;
  logic [4:0] prod_ptr, cons_ptr;
  logic mem_we, irq, overflow;
  logic [3:0] mem_idx;
  logic [255:0] mem_data;

  int n_chk = 0, n_bad = 0;
  logic [4:0] m_prod = '0, m_cons = '0;
  logic m_ovf = 1'b0;

  always #2.5 clk = ~clk;

  fault_evq u0 (
    .clk(clk), .rst_n(rst_n), .evq_enable(evq_enable), .evq_irq_enable(evq_irq_enable),
    .fault_valid(fault_valid), .fault_code(fault_code), .fault_sid(fault_sid),
    .fault_ssid(fault_ssid), .fault_iaddr(fault_iaddr), .fault_faddr(fault_faddr),
    .cons_wr(cons_wr), .cons_wdata(cons_wdata), .prod_ptr(prod_ptr), .cons_ptr(cons_ptr),
    .mem_we(mem_we), .mem_idx(mem_idx), .mem_data(mem_data), .irq(irq), .overflow(overflow)
  );

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic m_irq();
    return evq_irq_enable && (m_prod != m_cons);
  endfunction

  task automatic send(input logic [7:0] code, input logic [31:0] sid, input logic [19:0] ssid,
                      input logic [63:0] ia, input logic [63:0] fa, input string req);
    logic ok;
    logic [255:0] rec;
    ok = evq_enable && ((m_prod ^ m_cons) != 5'h10);
    rec = {fa[63:32], fa[31:0], ia[63:32], ia[31:0], 32'h0, 32'h0, sid, ssid, 4'h0, code};
    @(negedge clk);
    fault_valid = 1'b1; fault_code = code; fault_sid = sid; fault_ssid = ssid;
    fault_iaddr = ia; fault_faddr = fa;
    #1;
    chk({req, " write strobe"}, 256'(mem_we), 256'(ok));
    if (ok) begin
      chk({req, " slot R3"}, 256'(mem_idx), 256'(m_prod[3:0]));
      chk({req, " record R2"}, mem_data, rec);
    end
    @(negedge clk);
    fault_valid = 1'b0;
    if (ok) m_prod = m_prod + 5'd1;
    else if (evq_enable) m_ovf = 1'b1;
    chk({req, " prod_ptr"}, 256'(prod_ptr), 256'(m_prod));
    chk({req, " overflow"}, 256'(overflow), 256'(m_ovf));
  endtask

  task automatic set_cons(input logic [4:0] v);
    @(negedge clk);
    cons_wr = 1'b1; cons_wdata = v;
    @(negedge clk);
    cons_wr = 1'b0;
    m_cons = v;
    chk("R7 cons_ptr", 256'(cons_ptr), 256'(m_cons));
    chk("R8 irq after consumer write", 256'(irq), 256'(m_irq()));
  endtask

  task automatic t_reset();
    #1;
    chk("R1 prod_ptr", 256'(prod_ptr), 256'(0));
    chk("R1 cons_ptr", 256'(cons_ptr), 256'(0));
    chk("R1 irq", 256'(irq), 256'(0));
    chk("R1 overflow", 256'(overflow), 256'(0));
    chk("R1 mem_we", 256'(mem_we), 256'(0));
  endtask

  task automatic t_layout();
    evq_enable = 1'b1; evq_irq_enable = 1'b1;
    send(8'h10, 32'h0000_0003, 20'hABCDE, 64'h1122_3344_5566_7788,
         64'h99AA_BBCC_DDEE_F001, "R2 R3 translation fault");
    chk("R8 irq pending", 256'(irq), 256'(1));
    evq_irq_enable = 1'b0; #1;
    chk("R8 irq masked", 256'(irq), 256'(0));
    evq_irq_enable = 1'b1; #1;
  endtask

  task automatic t_disabled();
    evq_enable = 1'b0;
    send(8'h13, 32'hDEAD_BEEF, 20'h12345, 64'h1, 64'h2, "R4 disabled");
    evq_enable = 1'b1;
    chk("R4 overflow untouched", 256'(overflow), 256'(0));
  endtask

  task automatic t_fill_overflow();
    logic [7:0] codes [7] = '{8'h01, 8'h02, 8'h04, 8'h0A, 8'h12, 8'h13, 8'h20};
    set_cons(5'd1);
    chk("R8 irq empty", 256'(irq), 256'(0));
    for (int i = 0; i < 16; i++)
      send(codes[i % 7], 32'(i * 7 + 1), 20'(i * 4099), {32'(i), 32'hC0DE_0000 + 32'(i)},
           {32'hFE00_0000 + 32'(i), 32'(~i)}, "R3 fill");
    chk("R5 full prod_ptr", 256'(prod_ptr), 256'(5'd17));
    send(8'h20, 32'h55, 20'h55, 64'h5, 64'h6, "R5 dropped when full");
    @(negedge clk);
    chk("R6 overflow sticky", 256'(overflow), 256'(1));
    set_cons(5'd17);
    chk("R6 overflow after drain", 256'(overflow), 256'(1));
    evq_enable = 1'b0;
    @(negedge clk);
    m_ovf = 1'b0;
    chk("R6 overflow cleared", 256'(overflow), 256'(0));
    evq_enable = 1'b1;
  endtask

  task automatic t_same_cycle();
    // R7: fault in a consumer-write cycle is judged against the old consumer
    set_cons(5'd1);
    for (int i = 0; i < 16; i++)
      send(8'h04, 32'(i), 20'(i), 64'(i), 64'(i), "R7 refill");
    @(negedge clk);
    cons_wr = 1'b1; cons_wdata = 5'd17;
    fault_valid = 1'b1; fault_code = 8'h0A;
    #1;
    chk("R7 same-cycle fault still full", 256'(mem_we), 256'(0));
    @(negedge clk);
    cons_wr = 1'b0; fault_valid = 1'b0;
    m_cons = 5'd17; m_ovf = 1'b1;
    chk("R7 cons loaded", 256'(cons_ptr), 256'(5'd17));
    chk("R7 prod held", 256'(prod_ptr), 256'(5'd17));
    evq_enable = 1'b0;
    @(negedge clk);
    m_ovf = 1'b0;
    evq_enable = 1'b1;
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 14; i++)
      send(8'h12, 32'(i), 20'(i), 64'(i), 64'(i), "R9 advance");
    chk("R9 at 31", 256'(prod_ptr), 256'(5'd31));
    send(8'h01, 32'h7, 20'h7, 64'h7, 64'h7, "R9 slot 15");
    chk("R9 wrapped to 0", 256'(prod_ptr), 256'(0));
    set_cons(5'd0);
    send(8'h02, 32'h8, 20'h8, 64'h8, 64'h8, "R9 slot 0");
    chk("R9 prod after wrap", 256'(prod_ptr), 256'(1));
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_layout();
    t_disabled();
    t_fill_overflow();
    t_same_cycle();
    t_wrap();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule